// File: doc/BRIEF.md
# Bidirectional Mailbox Interrupt Register Block

This block sits between a PCI Express host register port and a local memory-mapped register port and carries short 32-bit messages in both directions. The host side owns eight host-to-local mailboxes, and the local side owns eight local-to-host mailboxes. Each side can read the other side's mailboxes but cannot write them. Every mailbox write raises a pending bit that belongs to the opposite side. That side clears the bit by writing a one to it.

On the host side, the pending mailbox bits and sixteen level-sensitive local interrupt lines form 24 interrupt sources. A host-owned enable register gates these sources into one host interrupt. A read-only vector register names the enabled pending source with the lowest index, so host software knows which source to service first. On the local side, any pending host-to-local mailbox bit drives the local interrupt directly.

Both ports are single-cycle: a write takes effect at the next rising clock edge, and read data is driven combinationally from the address in the same cycle.

Top module: `mbox_irq_regs`

## Requirements
- R1: Host writes at 0x800 + 4*N (N = 0..7) store mailbox N of the host-to-local set. The value reads back at the same offset on both ports.
- R2: A host write to host-to-local mailbox N sets bit N of the local pending register, which the local port reads at 0x040 in bits [7:0]. `local_irq` is high whenever any of these bits is set.
- R3: Writes on the local port to 0x800..0x81C, and writes on the host port to 0x900..0x91C, leave those mailboxes unchanged.
- R4: A local write at 0x900 + 4*N stores local-to-host mailbox N, which both ports read at that offset. The same write sets bit 16+N of the host pending register, which the host port reads at 0x040.
- R5: Writing ones to a pending register clears the matching bits. The local side clears through local 0x040 bits [7:0]. The host side clears through host 0x040 bits [23:16].
- R6: If a set and a clear of the same pending bit fall in the same cycle, the bit ends up set.
- R7: Host 0x040 bits [15:0] show the live levels of `irq_in`. Host 0x050 bits [23:0] hold the source enables. `host_irq` is high exactly when some source is both pending and enabled.
- R8: Host 0x060 bits [4:0] report the enabled pending source with the lowest index. Inputs 0..15 map to vectors 0..15 and mailboxes 0..7 map to vectors 16..23. The register reads 31 when no enabled source is pending.
- R9: Reserved bits and unmapped offsets read as zero, and writes to them have no effect. After reset, every register is zero.
- R10: Read data follows the address in the same cycle, and a write is visible on the cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 12 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data |
| l_wr | input | 1 | Local write strobe |
| l_addr | input | 12 | Local byte address |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data |
| irq_in | input | 16 | Level-sensitive local interrupt lines |
| host_irq | output | 1 | Combined host interrupt |
| local_irq | output | 1 | Local mailbox interrupt |

## Verification
The only functions that can collide in a single cycle are setting and clearing the same pending bit. A set comes from a mailbox write on one port, and a clear comes from a write-1-to-clear on the other port. The bench drives both strobes in the same clock cycle, once for the local pending register and once for the host pending register. It then reads the pending register back and passes only if the bit is still set. It also checks that a later clear on its own removes the bit.

// File: rtl/mbox_irq_regs.sv
module mbox_irq_regs #(
  parameter int NMB = 8,
  parameter int NIRQ = 16,
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int VW = 5,
  parameter logic [AW-1:0] H2L_BASE = 12'h800,
  parameter logic [AW-1:0] L2H_BASE = 12'h900,
  parameter logic [AW-1:0] PEND_OFS = 12'h040,
  parameter logic [AW-1:0] EN_OFS   = 12'h050,
  parameter logic [AW-1:0] VEC_OFS  = 12'h060
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            h_wr,
  input  logic [AW-1:0]   h_addr,
  input  logic [DW-1:0]   h_wdata,
  output logic [DW-1:0]   h_rdata,
  input  logic            l_wr,
  input  logic [AW-1:0]   l_addr,
  input  logic [DW-1:0]   l_wdata,
  output logic [DW-1:0]   l_rdata,
  input  logic [NIRQ-1:0] irq_in,
  output logic            host_irq,
  output logic            local_irq
);
  localparam int NSRC = NIRQ + NMB;
  localparam int IW = $clog2(NMB);
  localparam int SPAN = IW + 2;

  logic [NMB-1:0][DW-1:0] h2l_mb, l2h_mb;
  logic [NMB-1:0] lpend, hpend, lset, lclr, hset, hclr;
  logic [NSRC-1:0] en, hsrc, act;
  logic [VW-1:0] vec;

  wire [IW-1:0] h_idx = h_addr[SPAN-1:2];
  wire [IW-1:0] l_idx = l_addr[SPAN-1:2];
  wire h_h2l = h_addr[AW-1:SPAN] == H2L_BASE[AW-1:SPAN];
  wire h_l2h = h_addr[AW-1:SPAN] == L2H_BASE[AW-1:SPAN];
  wire l_h2l = l_addr[AW-1:SPAN] == H2L_BASE[AW-1:SPAN];
  wire l_l2h = l_addr[AW-1:SPAN] == L2H_BASE[AW-1:SPAN];

  assign lset = (h_wr && h_h2l) ? (NMB'(1) << h_idx) : '0;
  assign hset = (l_wr && l_l2h) ? (NMB'(1) << l_idx) : '0;
  assign lclr = (l_wr && l_addr == PEND_OFS) ? l_wdata[NMB-1:0] : '0;
  assign hclr = (h_wr && h_addr == PEND_OFS) ? h_wdata[NIRQ +: NMB] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h2l_mb <= '0;
      l2h_mb <= '0;
      lpend  <= '0;
      hpend  <= '0;
      en     <= '0;
    end else begin
      for (int i = 0; i < NMB; i++) begin
        if (lset[i]) h2l_mb[i] <= h_wdata;
        if (hset[i]) l2h_mb[i] <= l_wdata;
      end
      lpend <= (lpend & ~lclr) | lset;
      hpend <= (hpend & ~hclr) | hset;
      if (h_wr && h_addr == EN_OFS) en <= h_wdata[NSRC-1:0];
    end
  end

  assign hsrc = {hpend, irq_in};
  assign act = hsrc & en;
  assign host_irq = |act;
  assign local_irq = |lpend;

  always_comb begin
    vec = '1;
    for (int i = NSRC - 1; i >= 0; i--)
      if (act[i]) vec = VW'(i);
  end

  always_comb begin
    h_rdata = '0;
    if (h_h2l) h_rdata = h2l_mb[h_idx];
    else if (h_l2h) h_rdata = l2h_mb[h_idx];
    else if (h_addr == PEND_OFS) h_rdata[NSRC-1:0] = hsrc;
    else if (h_addr == EN_OFS) h_rdata[NSRC-1:0] = en;
    else if (h_addr == VEC_OFS) h_rdata[VW-1:0] = vec;
  end

  always_comb begin
    l_rdata = '0;
    if (l_h2l) l_rdata = h2l_mb[l_idx];
    else if (l_l2h) l_rdata = l2h_mb[l_idx];
    else if (l_addr == PEND_OFS) l_rdata[NMB-1:0] = lpend;
  end

  p_h2l_raises_lirq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_h2l) |=> local_irq);

  p_l2h_raises_hpend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && l_l2h) |=> hpend[$past(l_idx)]);

  p_local_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && l_h2l && !h_wr) |=> $stable(h2l_mb));

  p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_h2l && lclr[h_idx]) |=> lpend[$past(h_idx)]);

  p_idle_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !host_irq |-> (vec == '1));
endmodule

// File: tb/mbox_irq_regs_tb.sv
`timescale 1ns/1ps
module mbox_irq_regs_tb;
  logic clk = 0, rst_n = 0;
  logic h_wr = 0, l_wr = 0;
  logic [11:0] h_addr = 0, l_addr = 0;
  logic [31:0] h_wdata = 0, l_wdata = 0, h_rdata, l_rdata;
  logic [15:0] irq_in = 0;
  logic host_irq, local_irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mbox_irq_regs u_dut (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .irq_in(irq_in), .host_irq(host_irq), .local_irq(local_irq)
  );

  // entry: {req[3:0], op[1:0], addr[11:0], data[31:0]}
  // op 0 host write, 1 local write, 2 host read check, 3 local read check
  localparam int NV = 21;
  localparam logic [49:0] TBL [NV] = '{
    {4'd1, 2'd0, 12'h800, 32'h1111_1111},
    {4'd1, 2'd0, 12'h81C, 32'hDEAD_BEEF},
    {4'd1, 2'd2, 12'h800, 32'h1111_1111},  // R1
    {4'd1, 2'd3, 12'h81C, 32'hDEAD_BEEF},  // R1
    {4'd2, 2'd3, 12'h040, 32'h0000_0081},  // R2
    {4'd3, 2'd1, 12'h804, 32'h0000_0055},
    {4'd3, 2'd3, 12'h804, 32'h0000_0000},  // R3
    {4'd4, 2'd1, 12'h90C, 32'hCAFE_0003},
    {4'd4, 2'd2, 12'h90C, 32'hCAFE_0003},  // R4
    {4'd4, 2'd2, 12'h040, 32'h0008_0000},  // R4
    {4'd3, 2'd0, 12'h90C, 32'h0000_1234},
    {4'd3, 2'd3, 12'h90C, 32'hCAFE_0003},  // R3
    {4'd5, 2'd1, 12'h040, 32'h0000_0001},
    {4'd5, 2'd3, 12'h040, 32'h0000_0080},  // R5
    {4'd9, 2'd0, 12'h050, 32'hFFFF_FFFF},
    {4'd9, 2'd2, 12'h050, 32'h00FF_FFFF},  // R9
    {4'd8, 2'd2, 12'h060, 32'd19},         // R8
    {4'd5, 2'd0, 12'h040, 32'h0008_0000},
    {4'd5, 2'd2, 12'h040, 32'h0000_0000},  // R5
    {4'd8, 2'd2, 12'h060, 32'd31},         // R8
    {4'd9, 2'd2, 12'h300, 32'h0000_0000}   // R9
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic hw(input logic [11:0] a, input logic [31:0] d);
    h_wr = 1; h_addr = a; h_wdata = d;
    @(posedge clk); #1; h_wr = 0;
  endtask

  task automatic lw(input logic [11:0] a, input logic [31:0] d);
    l_wr = 1; l_addr = a; l_wdata = d;
    @(posedge clk); #1; l_wr = 0;
  endtask

  task automatic hr(input int req, input logic [11:0] a, input logic [31:0] e);
    h_addr = a; #1; chk(req, h_rdata, e, $sformatf("host read %h", a));
  endtask

  task automatic lr(input int req, input logic [11:0] a, input logic [31:0] e);
    l_addr = a; #1; chk(req, l_rdata, e, $sformatf("local read %h", a));
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9: reset state
    chk(9, 32'(host_irq), 0, "host_irq after reset");
    chk(9, 32'(local_irq), 0, "local_irq after reset");
    hr(9, 12'h050, 0);
    hr(9, 12'h800, 0);
    lr(9, 12'h900, 0);
    hr(8, 12'h060, 31);

    for (int i = 0; i < NV; i++) begin
      logic [49:0] e;
      e = TBL[i];
      case (e[45:44])
        2'd0: hw(e[43:32], e[31:0]);
        2'd1: lw(e[43:32], e[31:0]);
        2'd2: hr(int'(e[49:46]), e[43:32], e[31:0]);
        default: lr(int'(e[49:46]), e[43:32], e[31:0]);
      endcase
    end

    // R10: write visible on the next cycle, read follows the address
    h_wr = 1; h_addr = 12'h814; h_wdata = 32'hA5A5_0005;
    #1 chk(10, h_rdata, 0, "mailbox before edge");
    @(posedge clk); #1; h_wr = 0;
    chk(10, h_rdata, 32'hA5A5_0005, "mailbox after edge");
    lw(12'h040, 32'hFF);
    chk(2, 32'(local_irq), 0, "local_irq after full clear");

    // R6: simultaneous set and clear on both pending registers
    h_wr = 1; h_addr = 12'h808; h_wdata = 32'h2;
    l_wr = 1; l_addr = 12'h040; l_wdata = 32'h4;
    @(posedge clk); #1; h_wr = 0; l_wr = 0;
    lr(6, 12'h040, 32'h4);
    chk(6, 32'(local_irq), 1, "local_irq after collision");
    l_wr = 1; l_addr = 12'h914; l_wdata = 32'h7;
    h_wr = 1; h_addr = 12'h040; h_wdata = 32'h0020_0000;
    @(posedge clk); #1; h_wr = 0; l_wr = 0;
    hr(6, 12'h040, 32'h0020_0000);
    lw(12'h040, 32'h4);
    lr(5, 12'h040, 0);

    // R7 and R8: level inputs, priority, gating
    irq_in = 16'h0100;
    #1 chk(7, 32'(host_irq), 1, "host_irq from input 8");
    hr(7, 12'h040, 32'h0020_0100);
    hr(8, 12'h060, 8);
    irq_in = 16'h8000;
    hr(8, 12'h060, 15);
    hw(12'h050, 32'h00FF_0000);
    hr(8, 12'h060, 21);
    hw(12'h050, 32'h0);
    chk(7, 32'(host_irq), 0, "host_irq all disabled");
    hr(8, 12'h060, 31);
    hw(12'h050, 32'h0000_8000);
    chk(7, 32'(host_irq), 1, "host_irq input 15 enabled");
    irq_in = 0;
    #1 chk(7, 32'(host_irq), 0, "host_irq input dropped");
    hw(12'h050, 32'h00FF_FFFF);
    hw(12'h040, 32'h0020_0000);
    chk(5, 32'(host_irq), 0, "host_irq after host clear");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule